// File: doc/BRIEF.md
# Order-Preserving Load Compaction Network

This block gathers the next-step configurations of a bank of parallel state-machine copies and packs them into load slots for the same bank. One input word comes from each of the N-1 running copies, and one more comes from a branch request. A flag qualifies each word. Every flagged word lands in the lowest free output slot, and the words keep their input order. Each word holds a state code and the stream offset at which that copy's match attempt began. Because order survives the packing, a lower slot index always carries an older start offset. The selection logic downstream relies on this when it picks the leftmost match.

The branch word sits last in input order, since its offset is the current one and is therefore always the newest. The slot of every flagged word comes from a log-depth prefix count of the flags. A network of log2(N) shift stages then moves each word toward slot 0 by the number of unflagged words below it. When all N inputs are flagged there is no free slot for the branch word, so it is dropped and an overflow output is raised. A parameter adds an output register, so the block can sit in the second stage of a two-stage pipeline.

Top module: `cpack_net`

## Requirements
- R1: A flagged active input with index i appears in output slot k, where k is the number of flagged active inputs with an index below i. The slot's load flag is 1 and its configuration equals that input's word.
- R2: Words keep their input order. For two flagged inputs with i < j, the slot of i is lower than the slot of j.
- R3: When fewer than N-1 active flags are set and the branch flag is set, the branch word goes to the slot equal to the number of flagged active inputs.
- R4: Every slot at or above the number of placed words has load flag 0 and a configuration of all zeros. The set load flags therefore always form a contiguous run starting at slot 0.
- R5: When all N-1 active flags and the branch flag are set, the overflow output is 1, the branch word is discarded, and slot k carries active input k.
- R6: The overflow output is 0 whenever at least one input flag is clear.
- R7: The configuration of an unflagged input has no effect on any output.
- R8: A word is laid out as state in bits [21:16] and start offset in bits [15:0]. Active input k occupies bits [22k+21:22k] of the active configuration bus, and slot k uses the same bits of the load configuration bus.
- R9: With REG_OUT=1, outputs follow the inputs one clock later, and a synchronous active-high reset clears all outputs to 0. With REG_OUT=0, outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_flag_i | input | N-1 | Active flags of the running copies |
| act_cfg_i | input | (N-1)*22 | Active configuration words, copy k in word k |
| br_flag_i | input | 1 | Branch request flag |
| br_cfg_i | input | 22 | Branch configuration word |
| load_flag_o | output | N-1 | Load flags, one per slot |
| load_cfg_o | output | (N-1)*22 | Load configuration words, slot k in word k |
| ovf_o | output | 1 | Branch word dropped because no slot was free |

## Verification
The assertions assume that every input is driven to a known value on every clock while reset is low. They do not assume any relation between flags and words, so configuration bits under a clear flag may hold arbitrary values. The stimulus changes inputs only on the falling clock edge and fills unflagged words with non-zero values. This keeps it inside those assumptions while still exercising the masking rule.

// File: rtl/cpack_pkg.sv
package cpack_pkg;
    localparam int STATE_W = 6;
    localparam int OFF_W   = 16;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [OFF_W-1:0]   offset;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic cfg_t cfg_zero();
        cfg_t z;
        z.state  = '0;
        z.offset = '0;
        return z;
    endfunction
endpackage

// File: rtl/cpack_prefix.sv
module cpack_prefix #(
    parameter int NI = 8,
    parameter int LW = $clog2(NI)
) (
    input  logic [NI-1:0]         flag_i,
    output logic [NI-1:0][LW-1:0] shift_o
);
    localparam int LV   = $clog2(NI);
    localparam int CNTW = $clog2(NI + 1);

    logic [NI-1:0][CNTW-1:0] pc [LV+1];

    for (genvar i = 0; i < NI; i++) begin : g_init
        assign pc[0][i] = CNTW'(flag_i[i]);
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < NI; i++) begin : g_el
            if (i >= D) begin : g_add
                assign pc[l+1][i] = pc[l][i] + pc[l][i-D];
            end else begin : g_pass
                assign pc[l+1][i] = pc[l][i];
            end
        end
    end

    for (genvar i = 0; i < NI; i++) begin : g_shift
        logic [CNTW-1:0] below;
        assign below      = pc[LV][i] - CNTW'(flag_i[i]);
        assign shift_o[i] = flag_i[i] ? LW'(CNTW'(i) - below) : '0;
    end
endmodule

// File: rtl/cpack_stage.sv
module cpack_stage
    import cpack_pkg::*;
#(
    parameter int NI = 8,
    parameter int LW = $clog2(NI),
    parameter int K  = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NI-1:0]         v_i,
    input  cfg_t [NI-1:0]         d_i,
    input  logic [NI-1:0][LW-1:0] s_i,
    output logic [NI-1:0]         v_o,
    output cfg_t [NI-1:0]         d_o,
    output logic [NI-1:0][LW-1:0] s_o
);
    localparam int D = 1 << K;

    for (genvar j = 0; j < NI; j++) begin : g_pos
        logic take_up, keep;
        if (j + D < NI) begin : g_up
            assign take_up = v_i[j+D] & s_i[j+D][K];
        end else begin : g_none
            assign take_up = 1'b0;
        end
        assign keep = v_i[j] & ~s_i[j][K];

        always_comb begin
            v_o[j] = take_up | keep;
            d_o[j] = cfg_zero();
            s_o[j] = '0;
            if (take_up) begin
                d_o[j] = d_i[(j+D) % NI];
                s_o[j] = s_i[(j+D) % NI];
            end else if (keep) begin
                d_o[j] = d_i[j];
                s_o[j] = s_i[j];
            end
        end

        // R2: a moving word and a staying word never compete for one position
        p_no_collide_r2: assert property (@(posedge clk) disable iff (rst)
            !(take_up && keep));
    end
endmodule

// File: rtl/cpack_outreg.sv
module cpack_outreg
    import cpack_pkg::*;
#(
    parameter int M       = 7,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [M-1:0] v_i,
    input  cfg_t [M-1:0] d_i,
    input  logic         ovf_i,
    output logic [M-1:0] v_o,
    output cfg_t [M-1:0] d_o,
    output logic         ovf_o
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                v_o   <= '0;
                d_o   <= '0;
                ovf_o <= 1'b0;
            end else begin
                v_o   <= v_i;
                d_o   <= d_i;
                ovf_o <= ovf_i;
            end
        end

        // R9: one cycle of latency
        p_latency_r9: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (v_o == $past(v_i)) && (ovf_o == $past(ovf_i)));
    end else begin : g_comb
        assign v_o   = v_i;
        assign d_o   = d_i;
        assign ovf_o = ovf_i;
    end
endmodule

// File: rtl/cpack_net.sv
module cpack_net
    import cpack_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-2:0]         act_flag_i,
    input  logic [(N-1)*CFG_W-1:0] act_cfg_i,
    input  logic                 br_flag_i,
    input  logic [CFG_W-1:0]     br_cfg_i,
    output logic [N-2:0]         load_flag_o,
    output logic [(N-1)*CFG_W-1:0] load_cfg_o,
    output logic                 ovf_o
);
    localparam int M  = N - 1;
    localparam int NI = N;
    localparam int LW = $clog2(NI);
    localparam int NS = $clog2(NI);

    logic [NI-1:0]         all_v;
    cfg_t [NI-1:0]         all_d;
    logic [NI-1:0][LW-1:0] all_s;

    assign all_v = {br_flag_i, act_flag_i};
    for (genvar k = 0; k < M; k++) begin : g_unpack
        assign all_d[k] = cfg_t'(act_cfg_i[k*CFG_W +: CFG_W]);
    end
    assign all_d[M] = cfg_t'(br_cfg_i);

    cpack_prefix #(.NI(NI), .LW(LW)) prefix_i (
        .flag_i  (all_v),
        .shift_o (all_s)
    );

    logic [NI-1:0]         sv [NS+1];
    cfg_t [NI-1:0]         sd [NS+1];
    logic [NI-1:0][LW-1:0] ss [NS+1];

    assign sv[0] = all_v;
    assign sd[0] = all_d;
    assign ss[0] = all_s;

    for (genvar k = 0; k < NS; k++) begin : g_stage
        cpack_stage #(.NI(NI), .LW(LW), .K(k)) stage_i (
            .clk (clk),
            .rst (rst),
            .v_i (sv[k]),
            .d_i (sd[k]),
            .s_i (ss[k]),
            .v_o (sv[k+1]),
            .d_o (sd[k+1]),
            .s_o (ss[k+1])
        );
    end

    logic [NI-1:0]         fin_v;
    cfg_t [NI-1:0]         fin_d;
    logic [NI-1:0][LW-1:0] fin_s;
    assign fin_v = sv[NS];
    assign fin_d = sd[NS];
    assign fin_s = ss[NS];

    logic [M-1:0] lf_c;
    cfg_t [M-1:0] ld_c;
    logic         ovf_c;
    assign lf_c  = fin_v[M-1:0];
    assign ld_c  = fin_d[M-1:0];
    assign ovf_c = fin_v[M];

    cfg_t [M-1:0] ld_o;
    cpack_outreg #(.M(M), .REG_OUT(REG_OUT)) outreg_i (
        .clk   (clk),
        .rst   (rst),
        .v_i   (lf_c),
        .d_i   (ld_c),
        .ovf_i (ovf_c),
        .v_o   (load_flag_o),
        .d_o   (ld_o),
        .ovf_o (ovf_o)
    );
    assign load_cfg_o = ld_o;

    // R4: set load flags form one run from slot 0
    p_contig_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lf_c + M'(1)));

    // R1: every placed word equals the word of a flagged input further up
    for (genvar j = 0; j < NI; j++) begin : g_route_chk
        p_route_r1: assert property (@(posedge clk) disable iff (rst)
            fin_v[j] |-> (all_v[j + int'(fin_s[j])] &&
                          fin_d[j] == all_d[j + int'(fin_s[j])]));
    end

    // R4: empty slots carry zero words
    for (genvar j = 0; j < M; j++) begin : g_zero_chk
        p_zero_r4: assert property (@(posedge clk) disable iff (rst)
            !lf_c[j] |-> (ld_c[j] == cfg_zero()));
    end

    // R5/R6: overflow only when every input is flagged, and the branch is the one left over
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_c |-> (&all_v));
    p_drop_branch_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_c |-> (fin_d[M] == all_d[M] && (&lf_c)));

    // R1: the count of placed words matches the count of flags, capped at M
    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(lf_c) + $countones(ovf_c) == $countones(all_v));
endmodule

// File: tb/cpack_net_tb.sv
module cpack_net_tb_top;
    import cpack_pkg::*;

    localparam int CLK_P = 10;
    localparam int CW    = CFG_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    // dut_i : N=8, registered
    logic [6:0]      a_f8;
    logic [7*CW-1:0] a_c8;
    logic            b_f8;
    logic [CW-1:0]   b_c8;
    logic [6:0]      l_f8;
    logic [7*CW-1:0] l_c8;
    logic            o8;

    cpack_net #(.N(8), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .act_flag_i(a_f8), .act_cfg_i(a_c8),
        .br_flag_i(b_f8), .br_cfg_i(b_c8),
        .load_flag_o(l_f8), .load_cfg_o(l_c8), .ovf_o(o8));

    // dut16_i : N=16, combinational
    logic [14:0]      a_f16;
    logic [15*CW-1:0] a_c16;
    logic             b_f16;
    logic [CW-1:0]    b_c16;
    logic [14:0]      l_f16;
    logic [15*CW-1:0] l_c16;
    logic             o16;

    cpack_net #(.N(16), .REG_OUT(1'b0)) dut16_i (
        .clk(clk), .rst(rst), .act_flag_i(a_f16), .act_cfg_i(a_c16),
        .br_flag_i(b_f16), .br_cfg_i(b_c16),
        .load_flag_o(l_f16), .load_cfg_o(l_c16), .ovf_o(o16));

    // {expected overflow, branch flag, active flags} for N=8
    localparam logic [8:0] VEC [12] = '{
        9'h000, 9'h1FF, 9'h07F, 9'h080, 9'h001, 9'h055,
        9'h0AA, 9'h0F0, 9'h00F, 9'h081, 9'h0FE, 9'h040
    };

    logic [15:0]         st_f;
    logic [15:0][CW-1:0] st_c;

    // stable sequential compaction; branch is input ni-1
    task automatic model(input int ni, input logic [15:0] f, input logic [15:0][CW-1:0] c,
                         output logic [15:0] ef, output logic [15:0][CW-1:0] ec, output logic eo);
        int k = 0;
        ef = '0; ec = '0; eo = 1'b0;
        for (int i = 0; i < ni; i++) begin
            if (f[i]) begin
                if (k < ni - 1) begin
                    ef[k] = 1'b1; ec[k] = c[i]; k++;
                end else eo = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [CW*16-1:0] act, input logic [CW*16-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // fill all words, flagged or not, with non-zero values (R7 masking)
    task automatic make_words(input int seed);
        for (int i = 0; i < 16; i++)
            st_c[i] = {6'((seed + i) | 1), 16'(seed * 37 + i * 3 + 1)};
    endtask

    logic [15:0]         p8_f;
    logic [15:0][CW-1:0] p8_c;
    logic                p8_o;
    logic                p8_v = 1'b0;

    task automatic apply_and_check(input logic [15:0] f8, input logic [15:0] f16, input int seed,
                                   input int ovf_exp8);
        logic [15:0]         ef;
        logic [15:0][CW-1:0] ec;
        logic                eo;
        @(negedge clk);
        make_words(seed);
        a_f8 = f8[6:0]; b_f8 = f8[7]; b_c8 = st_c[7];
        for (int i = 0; i < 7; i++) a_c8[i*CW +: CW] = st_c[i];
        a_f16 = f16[14:0]; b_f16 = f16[15]; b_c16 = st_c[15];
        for (int i = 0; i < 15; i++) a_c16[i*CW +: CW] = st_c[i];
        #1;
        // comb instance, same cycle (R9)
        model(16, f16, st_c, ef, ec, eo);
        chk("R1 R4 flags n16", {(CW*16-15)'(0), l_f16}, {(CW*16-15)'(0), ef[14:0]});
        chk("R2 R3 R7 R8 cfg n16", {(CW*16-15*CW)'(0), l_c16}, {(CW*16-15*CW)'(0), ec[14:0]});
        chk("R5 R6 ovf n16", (CW*16)'(o16), (CW*16)'(eo));
        model(8, f8, st_c, p8_f, p8_c, p8_o);
        if (ovf_exp8 >= 0) chk("R5 R6 table ovf n8", (CW*16)'(p8_o), (CW*16)'(ovf_exp8));
        @(posedge clk); #1;
        // registered instance, one cycle later (R9)
        chk("R1 R4 R9 flags n8", (CW*16)'(l_f8), (CW*16)'(p8_f[6:0]));
        chk("R2 R3 R7 R8 cfg n8", (CW*16)'(l_c8), (CW*16)'({p8_c[6], p8_c[5], p8_c[4], p8_c[3],
                                                              p8_c[2], p8_c[1], p8_c[0]}));
        chk("R5 R6 ovf n8", (CW*16)'(o8), (CW*16)'(p8_o));
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        st_f = '0;
        make_words(5);
        a_f8 = 7'h7F; b_f8 = 1'b1; b_c8 = st_c[7];
        for (int i = 0; i < 7; i++) a_c8[i*CW +: CW] = st_c[i];
        a_f16 = '0; b_f16 = 1'b0; a_c16 = '0; b_c16 = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset clears registered outputs despite flagged inputs
        chk("R9 reset flags", (CW*16)'(l_f8), '0);
        chk("R9 reset cfg", (CW*16)'(l_c8), '0);
        chk("R9 reset ovf", (CW*16)'(o8), '0);
        @(negedge clk);
        rst = 1'b0;

        for (int t = 0; t < 12; t++)
            apply_and_check({8'h00, VEC[t][7:0]}, {VEC[t][7:0], VEC[t][7:0]}, t, int'(VEC[t][8]));

        // R5: all sixteen inputs flagged
        apply_and_check(16'h00FF, 16'hFFFF, 99, 1);
        // R3: branch alone, highest slot for branch at N-2 actives
        apply_and_check(16'h00BF, 16'hBFFF, 77, 0);

        for (int t = 0; t < 300; t++) begin
            logic [15:0] r;
            r = 16'($urandom);
            apply_and_check({8'h00, r[7:0]}, 16'($urandom) | ((t % 7 == 0) ? 16'hFFFF : 16'h0), 200 + t, -1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule